// File: doc/BRIEF.md
# Transmit Interrupt Status and Request Line

This block turns the status flags of a transmit FIFO into an interrupt status word and a single interrupt request line. It watches four conditions from the FIFO side: a half-empty flag, an empty flag, a busy flag, and a one-cycle pulse that marks the FIFO level dropping to zero after a drain. From these it forms three interrupt sources. The underrun source reflects a sticky underrun flag that this block owns. The transmit-request source reflects the half-empty flag. The transmit-complete source is true when the FIFO is empty and the transmitter is idle.

The status word does not follow the flags continuously. It is refreshed only when something could have changed the host's view: any host register write, a write to the enable mask, a write to the clear register, or a data request from the downstream sink. Between such events it holds its value. The host writes an enable mask. The request line is the registered OR of the status bits that are enabled. A narrower combined-interrupts view gives the low bits of the status word. The sticky underrun flag is set by the drain pulse. It is cleared only by a clear-register write with the underrun-clear bit set. If a set and a clear arrive in the same cycle, the set wins.

Top module: `txi_irq_ctrl`

## Requirements
- R1: A synchronous reset drives the status word, the enable mask, the sticky underrun flag and the request line to zero.
- R2: When the status word is refreshed, bit 0 (underrun) takes the value that the sticky underrun flag holds after that cycle's set or clear.
- R3: When the status word is refreshed, bit 1 (transmit request) takes the value of the half-empty input.
- R4: When the status word is refreshed, bit 2 (transmit complete) is 1 when the empty input is 1 and the busy input is 0, and is 0 otherwise.
- R5: The request line is 1 exactly when some bit of (status word AND enable mask) was 1 one cycle earlier. It lags a change of either register by one clock.
- R6: The combined-interrupts output equals the low 7 bits of the status word. Status bits 3 and above always read 0.
- R7: A drain pulse sets the sticky underrun flag. The flag then stays set until a clear-register write with bit 0 of the clear data at 1.
- R8: A drain pulse and an underrun-clear write in the same cycle leave the flag set.
- R9: The status word is refreshed on the clock after a cycle in which host_wr_i, mask_wr_i, clr_wr_i or sink_req_i is 1, and holds its value in every other cycle.
- R10: A mask write loads the enable mask from mask_wdata_i. A clear-register write whose bit 0 is 0 leaves the underrun flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| drain_empty_i | input | 1 | Pulse: FIFO level reached zero after a drain |
| half_empty_i | input | 1 | FIFO at or below half full |
| empty_i | input | 1 | FIFO holds no samples |
| busy_i | input | 1 | Transmitter is shifting a sample |
| host_wr_i | input | 1 | Host wrote some other register of the channel |
| sink_req_i | input | 1 | Downstream sink requested data |
| mask_wr_i | input | 1 | Enable-mask write strobe |
| mask_wdata_i | input | STAT_W | Enable-mask write data |
| clr_wr_i | input | 1 | Clear-register write strobe |
| clr_wdata_i | input | CLR_W | Clear-register write data; bit 0 clears underrun |
| underrun_o | output | 1 | Sticky underrun flag |
| status_o | output | STAT_W | Raw interrupt status word |
| all_ints_o | output | VIEW_W | Combined-interrupts view (low bits of status) |
| irq_o | output | 1 | Interrupt request line |

## Verification
If the strobes and flags are driven before clock edge k, the sticky flag and the status word show the result after edge k. The request line shows it after edge k+1, because it registers a status word or mask that was itself updated at edge k. Each vector therefore drives its inputs, advances one clock and checks the status word, then drops the strobes, advances a second clock and checks the request line. The directed tests also check that the status word holds when flags change with no refresh event, while the sticky flag already shows its new value.

// File: rtl/txi_pkg.sv
package txi_pkg;
  localparam int SRC_UNDERRUN = 0;
  localparam int SRC_TXREQ    = 1;
  localparam int SRC_TXDONE   = 2;
  localparam int NUM_SRC      = 3;

  typedef struct packed {
    logic half_empty;
    logic empty;
    logic busy;
  } fifo_flags_t;
endpackage

// File: rtl/txi_underrun_flag.sv
module txi_underrun_flag #(
  parameter int CLR_W      = 8,
  parameter int UR_CLR_BIT = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             drain_empty_i,
  input  logic             clr_wr_i,
  input  logic [CLR_W-1:0] clr_wdata_i,
  output logic             flag_next_o,
  output logic             flag_o
);
  logic clr_hit;

  always_comb begin
    clr_hit = clr_wr_i & clr_wdata_i[UR_CLR_BIT];
    if (drain_empty_i)
      flag_next_o = 1'b1;
    else if (clr_hit)
      flag_next_o = 1'b0;
    else
      flag_next_o = flag_o;
  end

  always_ff @(posedge clk) begin
    if (rst)
      flag_o <= 1'b0;
    else
      flag_o <= flag_next_o;
  end

  AST_UR_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    drain_empty_i |=> flag_o); // R8

  AST_UR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (!drain_empty_i && !(clr_wr_i && clr_wdata_i[UR_CLR_BIT])) |=> $stable(flag_o)); // R7

  AST_UR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (!drain_empty_i && clr_wr_i && clr_wdata_i[UR_CLR_BIT]) |=> !flag_o); // R7
endmodule

// File: rtl/txi_status_eval.sv
module txi_status_eval
  import txi_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              eval_i,
  input  logic              underrun_i,
  input  fifo_flags_t       flags_i,
  output logic [STAT_W-1:0] status_o
);
  logic [NUM_SRC-1:0] src;
  logic [STAT_W-1:0]  status_next;

  always_comb begin
    src               = '0;
    src[SRC_UNDERRUN] = underrun_i;
    src[SRC_TXREQ]    = flags_i.half_empty;
    src[SRC_TXDONE]   = flags_i.empty & ~flags_i.busy;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_bit
    if (i < NUM_SRC) begin : g_src
      assign status_next[i] = src[i];
    end else begin : g_rsvd
      assign status_next[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      status_o <= '0;
    else if (eval_i)
      status_o <= status_next;
  end

  AST_STATUS_HOLD: assert property (@(posedge clk) disable iff (rst)
    !eval_i |=> $stable(status_o)); // R9

  AST_TXREQ_MIRROR: assert property (@(posedge clk) disable iff (rst)
    eval_i |=> status_o[SRC_TXREQ] == $past(flags_i.half_empty)); // R3

  AST_TXDONE_RULE: assert property (@(posedge clk) disable iff (rst)
    eval_i |=> status_o[SRC_TXDONE] == $past(flags_i.empty && !flags_i.busy)); // R4
endmodule

// File: rtl/txi_irq_mask.sv
module txi_irq_mask #(
  parameter int STAT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mask_wr_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  input  logic [STAT_W-1:0] status_i,
  output logic              irq_o
);
  logic [STAT_W-1:0] enable_q;
  logic [STAT_W-1:0] masked;

  always_ff @(posedge clk) begin
    if (rst)
      enable_q <= '0;
    else if (mask_wr_i)
      enable_q <= mask_wdata_i;
  end

  for (genvar i = 0; i < STAT_W; i++) begin : g_mask
    assign masked[i] = status_i[i] & enable_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst)
      irq_o <= 1'b0;
    else
      irq_o <= |masked;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (rst)
    mask_wr_i |=> enable_q == $past(mask_wdata_i)); // R10

  AST_IRQ_LAG: assert property (@(posedge clk) disable iff (rst)
    $stable(status_i) && $stable(enable_q) |=> $stable(irq_o)); // R5
endmodule

// File: rtl/txi_irq_ctrl.sv
module txi_irq_ctrl
  import txi_pkg::*;
#(
  parameter int STAT_W     = 8,
  parameter int VIEW_W     = 7,
  parameter int CLR_W      = 8,
  parameter int UR_CLR_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              drain_empty_i,
  input  logic              half_empty_i,
  input  logic              empty_i,
  input  logic              busy_i,
  input  logic              host_wr_i,
  input  logic              sink_req_i,
  input  logic              mask_wr_i,
  input  logic [STAT_W-1:0] mask_wdata_i,
  input  logic              clr_wr_i,
  input  logic [CLR_W-1:0]  clr_wdata_i,
  output logic              underrun_o,
  output logic [STAT_W-1:0] status_o,
  output logic [VIEW_W-1:0] all_ints_o,
  output logic              irq_o
);
  localparam int VIEW_USED = (VIEW_W < STAT_W) ? VIEW_W : STAT_W;

  logic        ur_next;
  logic        eval;
  fifo_flags_t flags;

  assign eval  = host_wr_i | sink_req_i | mask_wr_i | clr_wr_i;
  assign flags = '{half_empty: half_empty_i, empty: empty_i, busy: busy_i};

  txi_underrun_flag #(.CLR_W(CLR_W), .UR_CLR_BIT(UR_CLR_BIT)) u_flag (
    .clk           (clk),
    .rst           (rst),
    .drain_empty_i (drain_empty_i),
    .clr_wr_i      (clr_wr_i),
    .clr_wdata_i   (clr_wdata_i),
    .flag_next_o   (ur_next),
    .flag_o        (underrun_o)
  );

  txi_status_eval #(.STAT_W(STAT_W)) u_eval (
    .clk        (clk),
    .rst        (rst),
    .eval_i     (eval),
    .underrun_i (ur_next),
    .flags_i    (flags),
    .status_o   (status_o)
  );

  txi_irq_mask #(.STAT_W(STAT_W)) u_mask (
    .clk          (clk),
    .rst          (rst),
    .mask_wr_i    (mask_wr_i),
    .mask_wdata_i (mask_wdata_i),
    .status_i     (status_o),
    .irq_o        (irq_o)
  );

  for (genvar i = 0; i < VIEW_W; i++) begin : g_view
    if (i < VIEW_USED) begin : g_live
      assign all_ints_o[i] = status_o[i];
    end else begin : g_zero
      assign all_ints_o[i] = 1'b0;
    end
  end

  AST_UR_MIRROR: assert property (@(posedge clk) disable iff (rst)
    eval |=> status_o[SRC_UNDERRUN] == underrun_o); // R2

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (rst)
    status_o[STAT_W-1:NUM_SRC] == '0); // R6
endmodule

// File: tb/txi_irq_ctrl_bench.sv
module txi_irq_ctrl_bench;
  logic       clk = 1'b0;
  logic       rst;
  logic       drain_empty_i, half_empty_i, empty_i, busy_i;
  logic       host_wr_i, sink_req_i, mask_wr_i, clr_wr_i;
  logic [7:0] mask_wdata_i, clr_wdata_i;
  logic       underrun_o, irq_o;
  logic [7:0] status_o;
  logic [6:0] all_ints_o;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  txi_irq_ctrl u_txi_irq_ctrl (
    .clk(clk), .rst(rst), .drain_empty_i(drain_empty_i),
    .half_empty_i(half_empty_i), .empty_i(empty_i), .busy_i(busy_i),
    .host_wr_i(host_wr_i), .sink_req_i(sink_req_i),
    .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
    .clr_wr_i(clr_wr_i), .clr_wdata_i(clr_wdata_i),
    .underrun_o(underrun_o), .status_o(status_o),
    .all_ints_o(all_ints_o), .irq_o(irq_o)
  );

  // {mask[2:0], half, empty, busy, exp_status[2:0], exp_irq}
  localparam int NV = 8;
  localparam logic [9:0] VEC [NV] = '{
    10'b111_110_110_1,
    10'b001_110_110_0,
    10'b010_101_010_1,
    10'b100_011_000_0,
    10'b100_010_100_1,
    10'b011_000_000_0,
    10'b110_001_000_0,
    10'b000_110_110_0
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic idle();
    drain_empty_i = 0; host_wr_i = 0; sink_req_i = 0;
    mask_wr_i = 0; clr_wr_i = 0; mask_wdata_i = '0; clr_wdata_i = '0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    idle();
    half_empty_i = 1; empty_i = 1; busy_i = 0;
    rst = 1;
    #2;
    tick(); tick();
    // R1: reset state
    check("R1 status", status_o, 0);
    check("R1 irq", irq_o, 0);
    check("R1 underrun", underrun_o, 0);
    rst = 0;
    tick();
    check("R9 no refresh after reset", status_o, 0);

    // Vector table: R3 R4 R5 R10
    for (int v = 0; v < NV; v++) begin
      mask_wr_i = 1; mask_wdata_i = {5'b0, VEC[v][9:7]};
      half_empty_i = VEC[v][6]; empty_i = VEC[v][5]; busy_i = VEC[v][4];
      tick();
      check("R3/R4 status vector", status_o, {5'b0, VEC[v][3:1]});
      idle();
      tick();
      check("R5 irq vector", irq_o, VEC[v][0]);
    end

    // R9: flags change without refresh event -> status holds
    half_empty_i = 0; empty_i = 0; busy_i = 1;
    tick(); tick();
    check("R9 hold", status_o, 8'h06);
    sink_req_i = 1;
    tick();
    idle();
    check("R9 sink refresh", status_o, 8'h00);

    // R7: drain pulse sets sticky flag; no refresh yet
    mask_wr_i = 1; mask_wdata_i = 8'h01;
    tick();
    idle();
    drain_empty_i = 1;
    tick();
    drain_empty_i = 0;
    check("R7 flag set", underrun_o, 1);
    check("R9 status waits", status_o, 8'h00);
    host_wr_i = 1;
    tick();
    host_wr_i = 0;
    check("R2 underrun bit", status_o, 8'h01);
    check("R6 view", all_ints_o, 7'h01);
    tick();
    check("R5 irq underrun", irq_o, 1);

    // R10: clear write with bit 0 low leaves flag
    clr_wr_i = 1; clr_wdata_i = 8'hFE;
    tick();
    idle();
    check("R10 flag kept", underrun_o, 1);
    check("R2 status kept", status_o, 8'h01);

    // R8: set and clear in the same cycle
    drain_empty_i = 1; clr_wr_i = 1; clr_wdata_i = 8'h01;
    tick();
    idle();
    check("R8 set wins", underrun_o, 1);
    check("R8 status", status_o, 8'h01);

    // R7: clear
    clr_wr_i = 1; clr_wdata_i = 8'h01;
    tick();
    idle();
    check("R7 cleared", underrun_o, 0);
    check("R2 status cleared", status_o, 8'h00);
    tick();
    check("R5 irq drops", irq_o, 0);

    // R6: view with all sources set
    half_empty_i = 1; empty_i = 1; busy_i = 0; drain_empty_i = 1; host_wr_i = 1;
    tick();
    idle();
    check("R6 status all", status_o, 8'h07);
    check("R6 view all", all_ints_o, 7'h07);

    // R1: reset mid-run
    rst = 1;
    tick();
    rst = 0;
    check("R1 status re-reset", status_o, 0);
    check("R1 underrun re-reset", underrun_o, 0);
    check("R1 irq re-reset", irq_o, 0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule